// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a read-only cache with two ways per set. Each set keeps a single prediction bit that names the way expected to hold the next requested line. The data multiplexer is steered by that bit as soon as the set is indexed, so the requested word reaches the output before the tag comparison has finished. When the tag comparison confirms the guess, the word is returned one cycle after the request is accepted. When the line sits in the other way, the controller corrects the prediction and returns the word one cycle later. A wrong guess therefore costs one extra cycle and does not cause a miss.

A request carries a byte address. The top bits form the tag, the middle bits select the set, and the low bits locate a 32-bit word inside a 256-bit line. When neither way holds the line, the block raises a line request on its fill port and waits for the memory to return the whole line. It then installs the line and replays the lookup, and the replay hits in the predicted way.

The controller has four states. IDLE accepts a request. LOOKUP compares both tags while the predicted way drives the output. RECOVER returns the word from the way that actually hit. FILL waits for the line from memory. The transitions are:
- IDLE→LOOKUP when a request is accepted.
- LOOKUP→IDLE on a predicted hit.
- LOOKUP→RECOVER on a hit in the other way.
- LOOKUP→FILL on a miss.
- RECOVER→IDLE always.
- FILL→LOOKUP when the line arrives.

Top module: `wpc_cache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `fill_req` are 0. Every valid bit and every prediction bit is cleared, so the first access to any set is a miss.
- R2: Address split:
  - tag = `req_addr[33:13]`
  - set = `req_addr[12:5]`
  - `fill_addr` equals `req_addr[33:5]`

  Lines whose set fields differ never evict each other.
- R3: `req_addr[4:2]` selects word w of the line, where word w is bits [32w+31:32w] of `fill_data`. `req_addr[1:0]` has no effect on the returned word.
- R4: When the line is in the predicted way, `rsp_valid` is high in the first cycle after the accepting edge, with the correct word, and no fill is requested.
- R5: When the line is in the non-predicted way, `rsp_valid` is high in the second cycle after the accepting edge and no fill is requested. The set's prediction then names that way, so a repeat access to the same line is a one-cycle hit.
- R6: On a miss, `fill_req` is raised with the line address and held stable until `fill_valid` arrives. The line is then installed and the word is returned with `rsp_valid`. `fill_req` and `rsp_valid` are never high together.
- R7: The fill way is chosen in this order:
  1. way 0 if it is invalid;
  2. otherwise way 1 if it is invalid;
  3. otherwise the least recently used way, which is the way not named by the prediction.

  After the fill the prediction names the filled way.
- R8: `req_ready` is high only in IDLE. A `req_valid` presented while the block is busy is ignored and produces no response.
- R9: `rsp_valid` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 34 | Byte address of the read |
| req_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_data | output | 32 | Returned word |
| fill_req | output | 1 | Line request to memory |
| fill_addr | output | 29 | Line address (tag and set) |
| fill_valid | input | 1 | Line from memory is present |
| fill_data | input | 256 | Returned line |

## Verification
Three events coincide on the edge that ends FILL: the line is written into a way, that way's valid bit is set, and the set's prediction is redirected to the same way. The replayed lookup in the following cycle must observe all three updates together. The bench provokes this with fills into way 1 while the prediction still names way 0, and with a fill into the least recently used way once both ways are valid. A correct design returns the post-fill response in a predicted-hit LOOKUP cycle with correct data, and the next access to the same line completes in one cycle. The bench also holds a stray request during a fill to confirm that it is ignored.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RECOVER,
        ST_FILL
    } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
    parameter int TAG_W = 21,
    parameter int SET_W = 8,
    parameter int WAYS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic             wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [WAYS-1:0]  hit_o,
    output logic [WAYS-1:0]  valid_o
);
    localparam int NSETS = 1 << SET_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [NSETS-1:0] vld;
        logic [TAG_W-1:0] tags [NSETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vld <= '0;
            else if (wr_en && wr_way == 1'(w))
                vld[wr_set] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w))
                tags[wr_set] <= wr_tag;
        end

        assign valid_o[w] = vld[rd_set];
        assign hit_o[w]   = vld[rd_set] && (tags[rd_set] == rd_tag);
    end
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
    parameter int SET_W  = 8,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 3,
    parameter int WAYS   = 2
) (
    input  logic                           clk,
    input  logic [SET_W-1:0]               rd_set,
    input  logic                           rd_way,
    input  logic [WSEL_W-1:0]              rd_word,
    input  logic                           wr_en,
    input  logic [SET_W-1:0]               wr_set,
    input  logic                           wr_way,
    input  logic [WORD_W*(1<<WSEL_W)-1:0]  wr_line,
    output logic [WORD_W-1:0]              word_o
);
    localparam int NSETS  = 1 << SET_W;
    localparam int LINE_W = WORD_W * (1 << WSEL_W);

    logic [LINE_W-1:0] line_w [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_W-1:0] lines [NSETS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w))
                lines[wr_set] <= wr_line;
        end

        assign line_w[w] = lines[rd_set];
    end

    // The way is chosen from the prediction, not from the tag compare.
    logic [LINE_W-1:0] sel_line;
    assign sel_line = line_w[rd_way];
    assign word_o   = sel_line[rd_word*WORD_W +: WORD_W];
endmodule

// File: rtl/wpc_predictor.sv
module wpc_predictor #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way,
    output logic             pred_o
);
    localparam int NSETS = 1 << SET_W;

    logic [NSETS-1:0] guess;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            guess <= '0;
        else if (upd_en)
            guess[upd_set] <= upd_way;
    end

    assign pred_o = guess[rd_set];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] hit,
    input  logic [1:0] valid,
    input  logic       pred,
    input  logic       fill_valid,
    output wpc_state_e state_o,
    output logic       accept_o,
    output logic       req_ready,
    output logic       rsp_valid,
    output logic       fill_req,
    output logic       upd_en,
    output logic       upd_way,
    output logic       install_en
);
    wpc_state_e state, nxt;
    logic pred_hit, alt_hit, victim;

    assign pred_hit = hit[pred];
    assign alt_hit  = hit[~pred];
    assign victim   = !valid[0] ? 1'b0 : (!valid[1] ? 1'b1 : ~pred);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt        = state;
        req_ready  = 1'b0;
        accept_o   = 1'b0;
        rsp_valid  = 1'b0;
        fill_req   = 1'b0;
        upd_en     = 1'b0;
        upd_way    = 1'b0;
        install_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept_o = 1'b1;
                    nxt      = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (pred_hit) begin
                    rsp_valid = 1'b1;
                    nxt       = ST_IDLE;
                end else if (alt_hit) begin
                    upd_en  = 1'b1;
                    upd_way = ~pred;
                    nxt     = ST_RECOVER;
                end else begin
                    nxt = ST_FILL;
                end
            end
            ST_RECOVER: begin
                rsp_valid = 1'b1;
                nxt       = ST_IDLE;
            end
            ST_FILL: begin
                fill_req = 1'b1;
                if (fill_valid) begin
                    install_en = 1'b1;
                    upd_en     = 1'b1;
                    upd_way    = victim;
                    nxt        = ST_LOOKUP;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache #(
    parameter int TAG_W  = 21,
    parameter int SET_W  = 8,
    parameter int OFF_W  = 5,
    parameter int WORD_W = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    input  logic [TAG_W+SET_W+OFF_W-1:0]            req_addr,
    output logic                                    req_ready,
    output logic                                    rsp_valid,
    output logic [WORD_W-1:0]                       rsp_data,
    output logic                                    fill_req,
    output logic [TAG_W+SET_W-1:0]                  fill_addr,
    input  logic                                    fill_valid,
    input  logic [WORD_W*(1<<(OFF_W-2))-1:0]        fill_data
);
    import wpc_pkg::*;

    localparam int ADDR_W = TAG_W + SET_W + OFF_W;
    localparam int WSEL_W = OFF_W - 2;

    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  cur_tag;
    logic [SET_W-1:0]  cur_set;
    logic [WSEL_W-1:0] cur_word;
    logic [1:0]        hit, valid;
    logic              pred, accept, upd_en, upd_way, install_en;
    wpc_state_e        state;

    assign cur_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign cur_set   = addr_q[OFF_W +: SET_W];
    assign cur_word  = addr_q[2 +: WSEL_W];
    assign fill_addr = addr_q[ADDR_W-1:OFF_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (accept)
            addr_q <= req_addr;
    end

    wpc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hit        (hit),
        .valid      (valid),
        .pred       (pred),
        .fill_valid (fill_valid),
        .state_o    (state),
        .accept_o   (accept),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .fill_req   (fill_req),
        .upd_en     (upd_en),
        .upd_way    (upd_way),
        .install_en (install_en)
    );

    wpc_tag_store #(.TAG_W(TAG_W), .SET_W(SET_W), .WAYS(2)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (cur_set),
        .rd_tag  (cur_tag),
        .wr_en   (install_en),
        .wr_set  (cur_set),
        .wr_way  (upd_way),
        .wr_tag  (cur_tag),
        .hit_o   (hit),
        .valid_o (valid)
    );

    wpc_data_store #(.SET_W(SET_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W), .WAYS(2)) u_data (
        .clk     (clk),
        .rd_set  (cur_set),
        .rd_way  (pred),
        .rd_word (cur_word),
        .wr_en   (install_en),
        .wr_set  (cur_set),
        .wr_way  (upd_way),
        .wr_line (fill_data),
        .word_o  (rsp_data)
    );

    wpc_predictor #(.SET_W(SET_W)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (cur_set),
        .upd_en  (upd_en),
        .upd_set (cur_set),
        .upd_way (upd_way),
        .pred_o  (pred)
    );

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/wpc_cache_chk.sv
module wpc_cache_chk #(
    parameter int FA_W = 29
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            fill_req,
    input logic            fill_valid,
    input logic [FA_W-1:0] fill_addr
);
    AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> fill_req); // R6
    AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> $stable(fill_addr)); // R6
    AST_FILL_NOT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && rsp_valid)); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_BUSY_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready); // R8
    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_RSP_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9
endmodule

bind wpc_cache wpc_cache_chk #(.FA_W(TAG_W + SET_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .fill_req   (fill_req),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr)
);

// File: tb/tb_wpc_cache.sv
`timescale 1ns/1ps
module tb_wpc_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [33:0]  req_addr = '0;
    logic         req_ready, rsp_valid, fill_req;
    logic [31:0]  rsp_data;
    logic [28:0]  fill_addr;
    logic         fill_valid = 1'b0;
    logic [255:0] fill_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int fills_seen = 0;

    always #5 clk = ~clk;

    wpc_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
        .fill_data(fill_data)
    );

    function automatic logic [31:0] word_of(input logic [28:0] la, input int w);
        return (32'(la) * 32'h9E3779B1) ^ (32'(w) * 32'h01030507) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [255:0] line_of(input logic [28:0] la);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = word_of(la, w);
        return l;
    endfunction

    function automatic logic [33:0] mk(input logic [20:0] t, input logic [7:0] s, input logic [4:0] o);
        return {t, s, o};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: answers a line request after three cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (fill_req && !fill_valid) begin
                cnt++;
                if (cnt == 3) begin
                    fill_valid = 1'b1;
                    fill_data  = line_of(fill_addr);
                    fills_seen++;
                end
            end else begin
                fill_valid = 1'b0;
                cnt = 0;
            end
        end
    end

    // kind: 1 predicted hit, 2 other-way hit, 3 miss
    task automatic access(input logic [33:0] a, input int kind, input string req);
        int cyc = 1;
        bit saw_fill = 0;
        logic [28:0] fa = '0;
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && cyc < 100) begin
            if (fill_req) begin saw_fill = 1; fa = fill_addr; end
            @(negedge clk);
            cyc++;
        end
        if (kind == 3) begin
            check(saw_fill && cyc > 2, {req, " miss latency"}, 64'(cyc), 64'd3);
            check(fa == a[33:5], "R2 fill line address", 64'(fa), 64'(a[33:5]));
        end else begin
            check(!saw_fill && cyc == kind, {req, " hit latency"}, 64'(cyc), 64'(kind));
        end
        check(rsp_data == word_of(a[33:5], int'(a[4:2])), {req, " data R3"},
              64'(rsp_data), 64'(word_of(a[33:5], int'(a[4:2]))));
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 single pulse", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        check(fill_req == 1'b0, "R1 no fill after reset", 64'(fill_req), 64'd0);
    endtask

    task automatic t_ways_and_lru();
        logic [33:0] a = mk(21'h00AAA, 8'h10, 5'd4);
        logic [33:0] b = mk(21'h00BBB, 8'h10, 5'd8);
        logic [33:0] c = mk(21'h00CCC, 8'h10, 5'd12);
        access(a, 3, "R1 first access miss");
        access(a, 1, "R4 predicted hit");
        access(b, 3, "R7 fill into invalid way");
        access(b, 1, "R7 prediction names filled way");
        access(a, 2, "R5 other-way hit");
        access(a, 1, "R5 prediction corrected");
        access(b, 2, "R5 other-way hit again");
        access(c, 3, "R7 miss with both valid");
        access(b, 2, "R7 LRU victim kept b");
        access(a, 3, "R7 LRU evicted a");
        access(c, 3, "R7 LRU evicted c");
    endtask

    task automatic t_words();
        logic [28:0] la = {21'h01234, 8'h33};
        access({la, 5'd0}, 3, "R3 line fetch");
        for (int w = 0; w < 8; w++) access({la, 3'(w), 2'b00}, 1, "R3 word select");
        access({la, 3'd5, 2'b11}, 1, "R3 low bits ignored");
    endtask

    task automatic t_sets();
        logic [33:0] x = mk(21'h00777, 8'h01, 5'd0);
        logic [33:0] y = mk(21'h00777, 8'h02, 5'd0);
        logic [33:0] z = mk(21'h00888, 8'h02, 5'd0);
        access(x, 3, "R2 set one fill");
        access(y, 3, "R2 set two fill");
        access(z, 3, "R2 set two second fill");
        access(x, 1, "R2 set one undisturbed");
    endtask

    task automatic t_busy();
        logic [33:0] a = mk(21'h0F00F, 8'h44, 5'd16);
        logic [33:0] s = mk(21'h0E00E, 8'h45, 5'd0);
        int pulses = 0;
        int f0 = fills_seen;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_addr = s;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin
                pulses++;
                req_valid = 1'b0;
                check(rsp_data == word_of(a[33:5], 4), "R8 data of first request",
                      64'(rsp_data), 64'(word_of(a[33:5], 4)));
            end else if (req_valid) begin
                check(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(pulses == 1, "R8 stray request ignored", 64'(pulses), 64'd1);
        check(fills_seen == f0 + 1, "R8 no fill for stray", 64'(fills_seen - f0), 64'd1);
        access(s, 3, "R8 stray line never installed");
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ways_and_lru();
        t_words();
        t_sets();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule